// File: doc/BRIEF.md
# Dual-width add/subtract flag unit

This block is the arithmetic and status slice of a small datapath. Each cycle it can add two operands, subtract one from the other, pass an operand through as a data transfer, or do nothing. The result lands in a destination register, and the unit updates a five-bit flag register with negative, overflow, zero and carry. The width at which the unit works is held in that same flag register as a width bit. When the bit is 0 the unit works on 16 bits. When it is 1 the unit works on the low 8 bits, and the upper byte of the destination is left alone.

Two bit masks let the surrounding control set or clear any flag directly, including the width bit. The masks are applied on top of whatever the operation produced in the same cycle. A change of the width bit takes effect from the next operation onward.

Top module: `dwidth_alu`

## Requirements
- R1: A synchronous active-low reset clears the destination register to 0x0000 and every flag bit to 0, which selects 16-bit operation.
- R2: Flag register bit positions are: 0 carry, 1 zero, 2 width (0 = 16-bit, 1 = 8-bit), 3 overflow, 4 negative. An operation uses the width bit as it stood before the clock edge that performs it.
- R3: Opcodes are 00 no-op, 01 add (A+B), 10 subtract (A-B) and 11 transfer (B). In 16-bit mode an add or subtract writes the 16-bit result. In 8-bit mode it writes only the low byte, and the upper byte of the destination keeps its value.
- R4: In 16-bit mode, overflow is set after an add or subtract whose signed result lies outside -32768..+32767, and cleared otherwise.
- R5: In 8-bit mode, overflow is set after an add or subtract whose signed result lies outside -128..+127, and cleared otherwise.
- R6: After an add, subtract or transfer, negative equals the top bit of the active width (bit 15 or bit 7) of the written value.
- R7: After an add, subtract or transfer, zero is 1 exactly when all bits of the active width of the written value are 0.
- R8: Carry after an add is the carry out of the active width. After a subtract it is 1 when no borrow occurred.
- R9: A transfer writes B at the active width, with the upper byte kept in 8-bit mode. It updates negative and zero and leaves overflow and carry unchanged.
- R10: In the same cycle, after the operation, each flag bit with a 1 in the set mask becomes 1 and each bit with a 1 in the clear mask becomes 0. When both masks hit a bit, the set mask wins. The width bit is included.
- R11: A no-op with both masks zero leaves the destination and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 2 | Operation select (see R3) |
| operand_a | input | 16 | First operand |
| operand_b | input | 16 | Second operand, also the transfer source |
| flag_set | input | 5 | Flags to force to 1 this cycle |
| flag_clr | input | 5 | Flags to force to 0 this cycle |
| result | output | 16 | Destination register |
| flags | output | 5 | Flag register, layout in R2 |

## Verification
Sums and differences are chosen to sit exactly on the signed and unsigned limits of both widths. These include 0x7FFF+1, 0xFFFF+1, 0x8000-1 and 0x7FFF-(-1), together with their byte-width counterparts. They separate signed overflow from unsigned carry, borrow from carry, and zero from a nonzero wrapped result. The 8-bit cases use operands whose upper bytes would give a different answer at 16 bits, so a unit that judges width wrongly or overwrites the upper byte is caught. Transfers of negative and zero values show that negative and zero move while overflow and carry stay put. Masked cycles, alone and combined with an operation, show that set takes precedence and that a width change does not affect the operation it arrives with.

// File: rtl/dwidth_alu_pkg.sv
// Package: shared opcode type and flag bit positions for the dual-width unit.
// Assumes a five-bit flag register; positions are fixed because the
// surrounding control decodes them.
package dwidth_alu_pkg;

    localparam int FLAG_W = 5;
    localparam int FL_C   = 0;
    localparam int FL_Z   = 1;
    localparam int FL_W8  = 2;
    localparam int FL_V   = 3;
    localparam int FL_N   = 4;

    typedef enum logic [1:0] {
        OP_NOP  = 2'b00,
        OP_ADD  = 2'b01,
        OP_SUB  = 2'b10,
        OP_XFER = 2'b11
    } op_e;

endpackage

// File: rtl/addsub_lane.sv
// Module: one adder/subtractor at a fixed width W.
// Produces the sum, the carry out (inverted borrow on subtract) and the
// signed overflow at that width. Purely combinational.
module addsub_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   ext;

    // Invert B and inject a carry-in for subtraction, then add at W+1 bits.
    always_comb begin
        b_eff = sub ? ~b : b;
        ext   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = ext[W-1:0];
        cout  = ext[W];
        ovf   = (a[W-1] == b_eff[W-1]) && (ext[W-1] != a[W-1]);
    end

endmodule

// File: rtl/flag_next.sv
// Module: next-state logic for the destination register and the flag register.
// Assumes both lane results are presented every cycle; picks the one that
// the width bit selects, merges it into the old destination, derives the
// flags and finally applies the set/clear masks (set wins).
module flag_next
    import dwidth_alu_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  op_e                 op,
    input  logic [DATA_W-1:0]   b_in,
    input  logic [DATA_W-1:0]   res_q,
    input  logic [FLAG_W-1:0]   flags_q,
    input  logic [DATA_W-1:0]   w_sum,
    input  logic                w_c,
    input  logic                w_v,
    input  logic [NARROW_W-1:0] n_sum,
    input  logic                n_c,
    input  logic                n_v,
    input  logic [FLAG_W-1:0]   set_m,
    input  logic [FLAG_W-1:0]   clr_m,
    output logic [DATA_W-1:0]   res_d,
    output logic [FLAG_W-1:0]   flags_d
);
    localparam int HI_W = DATA_W - NARROW_W;

    logic                mode8;
    logic                arith;
    logic [DATA_W-1:0]   wide_val;
    logic [NARROW_W-1:0] lo_val;
    logic                neg;
    logic                zero;
    logic [FLAG_W-1:0]   op_flags;

    // Select the value written at each width and derive its sign and zero.
    always_comb begin
        mode8    = flags_q[FL_W8];
        arith    = (op == OP_ADD) || (op == OP_SUB);
        wide_val = (op == OP_XFER) ? b_in : w_sum;
        lo_val   = (op == OP_XFER) ? b_in[NARROW_W-1:0] : n_sum;
        neg      = mode8 ? lo_val[NARROW_W-1] : wide_val[DATA_W-1];
        zero     = mode8 ? (lo_val == '0) : (wide_val == '0);
    end

    // Next destination value: hold on no-op, keep upper part in narrow mode.
    always_comb begin
        if (op == OP_NOP)
            res_d = res_q;
        else if (mode8)
            res_d = {res_q[DATA_W-1:DATA_W-HI_W], lo_val};
        else
            res_d = wide_val;
    end

    // Flags produced by the operation, then masks applied with set on top.
    always_comb begin
        op_flags = flags_q;
        if (op != OP_NOP) begin
            op_flags[FL_N] = neg;
            op_flags[FL_Z] = zero;
        end
        if (arith) begin
            op_flags[FL_V] = mode8 ? n_v : w_v;
            op_flags[FL_C] = mode8 ? n_c : w_c;
        end
        flags_d = (op_flags & ~clr_m) | set_m;
    end

endmodule

// File: rtl/dwidth_alu.sv
// Module: top of the dual-width add/subtract flag unit.
// Holds the destination and flag registers (synchronous active-low reset)
// and wires one full-width lane and one narrow lane to the next-state logic.
// Assumes NARROW_W < DATA_W.
module dwidth_alu
    import dwidth_alu_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          op_code,
    input  logic [DATA_W-1:0]   operand_a,
    input  logic [DATA_W-1:0]   operand_b,
    input  logic [FLAG_W-1:0]   flag_set,
    input  logic [FLAG_W-1:0]   flag_clr,
    output logic [DATA_W-1:0]   result,
    output logic [FLAG_W-1:0]   flags
);
    op_e                 op;
    logic                is_sub;
    logic [DATA_W-1:0]   w_sum;
    logic                w_c;
    logic                w_v;
    logic [NARROW_W-1:0] n_sum;
    logic                n_c;
    logic                n_v;
    logic [DATA_W-1:0]   res_d;
    logic [FLAG_W-1:0]   flags_d;
    logic [DATA_W-1:0]   res_q;
    logic [FLAG_W-1:0]   flags_q;

    assign op     = op_e'(op_code);
    assign is_sub = (op == OP_SUB);

    addsub_lane #(.W(DATA_W)) u_wide (
        .a    (operand_a),
        .b    (operand_b),
        .sub  (is_sub),
        .sum  (w_sum),
        .cout (w_c),
        .ovf  (w_v)
    );

    addsub_lane #(.W(NARROW_W)) u_narrow (
        .a    (operand_a[NARROW_W-1:0]),
        .b    (operand_b[NARROW_W-1:0]),
        .sub  (is_sub),
        .sum  (n_sum),
        .cout (n_c),
        .ovf  (n_v)
    );

    flag_next #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_next (
        .op      (op),
        .b_in    (operand_b),
        .res_q   (res_q),
        .flags_q (flags_q),
        .w_sum   (w_sum),
        .w_c     (w_c),
        .w_v     (w_v),
        .n_sum   (n_sum),
        .n_c     (n_c),
        .n_v     (n_v),
        .set_m   (flag_set),
        .clr_m   (flag_clr),
        .res_d   (res_d),
        .flags_d (flags_d)
    );

    // Destination and flag registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
        end else begin
            res_q   <= res_d;
            flags_q <= flags_d;
        end
    end

    assign result = res_q;
    assign flags  = flags_q;

endmodule

// File: rtl/dwidth_alu_chk.sv
// Module: assertion checker for dwidth_alu, attached by the bind below.
// Observes only the ports of the top module.
module dwidth_alu_chk
    import dwidth_alu_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          op_code,
    input logic [FLAG_W-1:0]   flag_set,
    input logic [FLAG_W-1:0]   flag_clr,
    input logic [DATA_W-1:0]   result,
    input logic [FLAG_W-1:0]   flags
);
    logic no_mask;
    assign no_mask = (flag_set == '0) && (flag_clr == '0);

    // R11
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 2'b00 && no_mask) |=> ($stable(result) && $stable(flags)));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set != '0) |=> ((flags & $past(flag_set)) == $past(flag_set)));

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_clr & ~flag_set) != '0) |=> ((flags & $past(flag_clr & ~flag_set)) == '0));

    // R3
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FL_W8] && op_code != 2'b00)
        |=> (result[DATA_W-1:NARROW_W] == $past(result[DATA_W-1:NARROW_W])));

    // R6
    negative_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code != 2'b00 && no_mask)
        |=> (flags[FL_N] == (flags[FL_W8] ? result[NARROW_W-1] : result[DATA_W-1])));

    // R7
    zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code != 2'b00 && no_mask)
        |=> (flags[FL_Z] == (flags[FL_W8] ? (result[NARROW_W-1:0] == '0) : (result == '0))));

    // R9
    xfer_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 2'b11 && no_mask)
        |=> ($stable(flags[FL_V]) && $stable(flags[FL_C])));

endmodule

bind dwidth_alu dwidth_alu_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_code  (op_code),
    .flag_set (flag_set),
    .flag_clr (flag_clr),
    .result   (result),
    .flags    (flags)
);

// File: tb/tb_dwidth_alu.sv
module tb_dwidth_alu;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 13;
    localparam logic [4:0] M_C = 5'h01, M_Z = 5'h02, M_W8 = 5'h04;

    // {width8, op, a, b, expected result, expected flags}
    localparam logic [55:0] VEC [NVEC] = '{
        {1'b0, 2'b01, 16'h1234, 16'h0001, 16'h1235, 5'h00}, // R3 plain add
        {1'b0, 2'b01, 16'h7FFF, 16'h0001, 16'h8000, 5'h18}, // R4 R6 signed overflow
        {1'b0, 2'b01, 16'hFFFF, 16'h0001, 16'h0000, 5'h03}, // R7 R8 carry, V cleared
        {1'b0, 2'b10, 16'h8000, 16'h0001, 16'h7FFF, 5'h09}, // R4 R8 sub overflow, no borrow
        {1'b0, 2'b10, 16'h0001, 16'h0002, 16'hFFFF, 5'h10}, // R8 borrow
        {1'b1, 2'b01, 16'h1A7F, 16'h0001, 16'hFF80, 5'h1C}, // R5 R3 byte overflow
        {1'b1, 2'b01, 16'h00FF, 16'h0001, 16'hFF00, 5'h07}, // R7 R8 byte zero/carry
        {1'b1, 2'b10, 16'h0080, 16'h0001, 16'hFF7F, 5'h0D}, // R5 byte sub overflow
        {1'b1, 2'b10, 16'h1200, 16'h3401, 16'hFFFF, 5'h14}, // R5 R8 byte borrow
        {1'b0, 2'b11, 16'h0000, 16'h8001, 16'h8001, 5'h10}, // R9 wide transfer
        {1'b1, 2'b11, 16'h0000, 16'h0000, 16'h8000, 5'h06}, // R9 byte transfer
        {1'b0, 2'b10, 16'h5000, 16'h5000, 16'h0000, 5'h03}, // R7 equal sub
        {1'b0, 2'b10, 16'h7FFF, 16'hFFFF, 16'h8000, 5'h18}  // R4 sub of -1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_code = 2'b00;
    logic [15:0] operand_a = '0;
    logic [15:0] operand_b = '0;
    logic [4:0]  flag_set = '0;
    logic [4:0]  flag_clr = '0;
    logic [15:0] result;
    logic [4:0]  flags;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dwidth_alu dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_code   (op_code),
        .operand_a (operand_a),
        .operand_b (operand_b),
        .flag_set  (flag_set),
        .flag_clr  (flag_clr),
        .result    (result),
        .flags     (flags)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual still running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, then idle; ends at a falling edge.
    task automatic apply(input logic [1:0] o, input logic [15:0] a, input logic [15:0] b,
                         input logic [4:0] s, input logic [4:0] c);
        @(negedge clk);
        op_code = o; operand_a = a; operand_b = b; flag_set = s; flag_clr = c;
        @(negedge clk);
        op_code = 2'b00; operand_a = '0; operand_b = '0; flag_set = '0; flag_clr = '0;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 result", result, 16'h0000);
        check("R1 flags", {11'b0, flags}, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [55:0] v;
            v = VEC[i];
            if (v[55]) apply(2'b00, 16'h0, 16'h0, M_W8, 5'h00);
            else       apply(2'b00, 16'h0, 16'h0, 5'h00, M_W8);
            apply(v[54:53], v[52:37], v[36:21], 5'h00, 5'h00);
            check($sformatf("R3-R9 vec%0d result", i), result, v[20:5]);
            check($sformatf("R2 R4-R9 vec%0d flags", i), {11'b0, flags}, {11'b0, v[4:0]});
        end

        // R10: set and clear on every bit at once, set wins; destination held
        apply(2'b00, 16'h0, 16'h0, 5'h1F, 5'h1F);
        check("R10 set wins", {11'b0, flags}, 16'h001F);
        check("R10 R11 result held", result, 16'h8000);
        apply(2'b00, 16'h0, 16'h0, 5'h00, 5'h1F);
        check("R10 clear all", {11'b0, flags}, 16'h0000);

        // R10: mask on top of an add in the same cycle
        apply(2'b01, 16'h0001, 16'h0001, M_Z, M_C);
        check("R10 mask with add result", result, 16'h0002);
        check("R10 mask with add flags", {11'b0, flags}, 16'h0002);

        // R2: width change arrives with an add, add still runs at 16 bits
        apply(2'b00, 16'h0, 16'h0, 5'h00, 5'h1F);
        apply(2'b01, 16'h00FF, 16'h0001, M_W8, 5'h00);
        check("R2 old width used", result, 16'h0100);
        check("R2 width bit set", {11'b0, flags}, 16'h0004);
        apply(2'b01, 16'h0001, 16'h0001, 5'h00, 5'h00);
        check("R2 R3 new width used", result, 16'h0102);

        // R11: idle with busy operands holds everything
        apply(2'b00, 16'hFFFF, 16'hFFFF, 5'h00, 5'h00);
        check("R11 result", result, 16'h0102);
        check("R11 flags", {11'b0, flags}, 16'h0004);

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run result", result, 16'h0000);
        check("R1 mid-run flags", {11'b0, flags}, 16'h0000);
        rst_n = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule